// File: doc/BRIEF.md
# Distributed DMA Channel Remap Decoder

The block watches host I/O accesses and decides which ones fall on a per-channel DMA controller register set that has been moved into a relocatable I/O window. The window starts on a 256-byte boundary given by a 32-bit base register. Inside the window each channel owns a 16-byte register set. When an access lands on a channel that software has enabled for the downstream slot, the block raises a claim flag so the bridge forwards the access. It also reports the decoded channel number and the offset within that channel's registers.

Software sets up the block through a byte-wide configuration port. The base register is written as four bytes at offsets 58h to 5Bh, and the channel enable mask is written at offset 5Ch. Bit 4 of the mask stands in the cascade channel's position. It is hardwired to zero, which marks this block as the secondary controller.

Top module: `dma_remap_dec`

## Requirements
- R1: After reset the base register reads back 00h at offsets 59h, 5Ah and 5Bh. A byte written at one of those offsets reads back unchanged from the next cycle. Offset 59h holds address bits 15:8, 5Ah holds bits 23:16 and 5Bh holds bits 31:24.
- R2: Offset 58h (base bits 7:0) always reads 00h, and writes to it have no effect on reads or on decoding.
- R3: The channel mask at 5Ch resets to 00h. Bits 0-3 and 5-7 read back the written value, and bit n set enables channel n.
- R4: Bit 4 of the channel mask always reads 0, whatever value is written.
- R5: claim_o is 1 in the same cycle when all of the following hold: io_strobe_i is 1, io_addr_i[31:8] equals base bits 31:8, io_addr_i[7] is 0, and the mask bit for channel io_addr_i[6:4] is set.
- R6: claim_o is 0 whenever io_strobe_i is 0.
- R7: An access to a channel whose mask bit is clear is not claimed.
- R8: Channel 4 (io_addr_i[6:4] = 4) is never claimed.
- R9: While base bits 31:8 are all zero, nothing is claimed.
- R10: chan_o always equals io_addr_i[6:4], and reg_off_o always equals io_addr_i[3:0].
- R11: Accesses in the upper half of the window (io_addr_i[7] = 1) are not claimed.
- R12: Configuration offsets outside 58h to 5Ch read 00h, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data at cfg_addr_i (combinational) |
| io_addr_i | input | 32 | Host I/O address |
| io_strobe_i | input | 1 | I/O access valid |
| claim_o | output | 1 | Forward the access to the slot |
| chan_o | output | 3 | Decoded channel number |
| reg_off_o | output | 4 | Register offset within the channel set |

## Verification
The bench checks the window edges: the addresses just below and just above the 256-byte window, a mismatch only in the top address bit, and the upper half of the window. A design that compares too few base bits, or ignores address bit 7, would claim these accesses. It writes all ones to the mask and to byte 58h. A design that stores bit 4 or the low base byte would read them back as set, or would shift the window. It leaves the base at zero with every channel enabled, which catches a decoder that claims low I/O space straight after reset. The cascade channel and the disabled channels are also probed, which catches a decoder that forwards every access in the window.

// File: rtl/dma_remap_pkg.sv
package dma_remap_pkg;
  localparam int unsigned IO_AW      = 32;
  localparam int unsigned WIN_LSB    = 8;   // 256-byte window
  localparam int unsigned CH_LSB     = 4;   // 16-byte set per channel
  localparam int unsigned N_CH       = 8;
  localparam int unsigned CH_W       = $clog2(N_CH);
  localparam int unsigned N_BASE_B   = IO_AW / 8;
  localparam logic [7:0]  OFF_BASE   = 8'h58;
  localparam logic [7:0]  OFF_MASK   = 8'h5C;
  localparam int unsigned CASCADE_CH = 4;
endpackage

// File: rtl/dma_remap_cfg.sv
module dma_remap_cfg
  import dma_remap_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [7:0]           addr_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  output logic [IO_AW-1:WIN_LSB] base_hi_o,
  output logic [N_CH-1:0]      mask_o
);
  localparam logic [N_CH-1:0] RO_MASK = N_CH'(1) << CASCADE_CH;

  logic [7:0]      base_b_q [N_BASE_B];
  logic [N_CH-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < N_BASE_B; b++) base_b_q[b] <= '0;
      mask_q <= '0;
    end else if (we_i) begin
      // byte 0 stays zero: window is 256-byte aligned
      for (int b = 1; b < N_BASE_B; b++)
        if (addr_i == OFF_BASE + 8'(b)) base_b_q[b] <= wdata_i;
      if (addr_i == OFF_MASK) mask_q <= wdata_i & ~RO_MASK;
    end
  end

  for (genvar b = 1; b < N_BASE_B; b++) begin : g_base
    assign base_hi_o[b*8 +: 8] = base_b_q[b];
  end

  assign mask_o = mask_q;

  always_comb begin
    rdata_o = '0;
    for (int b = 1; b < N_BASE_B; b++)
      if (addr_i == OFF_BASE + 8'(b)) rdata_o = base_b_q[b];
    if (addr_i == OFF_MASK) rdata_o = mask_q;
  end

  logic unused_b0;
  assign unused_b0 = ^base_b_q[0];
endmodule

// File: rtl/dma_remap_win.sv
module dma_remap_win
  import dma_remap_pkg::*;
(
  input  logic [IO_AW-1:WIN_LSB] base_hi_i,
  input  logic [N_CH-1:0]        mask_i,
  input  logic [IO_AW-1:0]       addr_i,
  input  logic                   strobe_i,
  output logic                   claim_o,
  output logic [CH_W-1:0]        chan_o,
  output logic [CH_LSB-1:0]      off_o
);
  logic [N_CH-1:0] ch_en;
  logic            base_set, in_win, low_half;

  for (genvar c = 0; c < N_CH; c++) begin : g_en
    if (c == CASCADE_CH) begin : g_casc
      assign ch_en[c] = 1'b0;
    end else begin : g_norm
      assign ch_en[c] = mask_i[c];
    end
  end

  assign base_set = |base_hi_i;
  assign in_win   = addr_i[IO_AW-1:WIN_LSB] == base_hi_i;
  assign low_half = ~addr_i[WIN_LSB-1];
  assign chan_o   = addr_i[CH_LSB +: CH_W];
  assign off_o    = addr_i[CH_LSB-1:0];
  assign claim_o  = strobe_i & base_set & in_win & low_half & ch_en[chan_o];
endmodule

// File: rtl/dma_remap_dec.sv
module dma_remap_dec
  import dma_remap_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [7:0]  cfg_addr_i,
  input  logic [7:0]  cfg_wdata_i,
  output logic [7:0]  cfg_rdata_o,
  input  logic [31:0] io_addr_i,
  input  logic        io_strobe_i,
  output logic        claim_o,
  output logic [2:0]  chan_o,
  output logic [3:0]  reg_off_o
);
  logic [IO_AW-1:WIN_LSB] base_hi;
  logic [N_CH-1:0]        mask;

  dma_remap_cfg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .rdata_o  (cfg_rdata_o),
    .base_hi_o(base_hi),
    .mask_o   (mask)
  );

  dma_remap_win u_win (
    .base_hi_i(base_hi),
    .mask_i   (mask),
    .addr_i   (io_addr_i),
    .strobe_i (io_strobe_i),
    .claim_o  (claim_o),
    .chan_o   (chan_o),
    .off_o    (reg_off_o)
  );
endmodule

// File: rtl/dma_remap_dec_chk.sv
module dma_remap_dec_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  cfg_addr_i,
  input logic [7:0]  cfg_rdata_o,
  input logic [31:0] io_addr_i,
  input logic        io_strobe_i,
  input logic        claim_o,
  input logic [2:0]  chan_o,
  input logic [3:0]  reg_off_o
);
  p_no_casc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |-> chan_o != 3'd4);
  p_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_strobe_i |-> !claim_o);
  p_upper_half_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_addr_i[7] |-> !claim_o);
  p_low_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_addr_i == 8'h58 |-> cfg_rdata_o == 8'h00);
  p_role_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_addr_i == 8'h5C |-> !cfg_rdata_o[4]);
  p_fields_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_o == io_addr_i[6:4] && reg_off_o == io_addr_i[3:0]);
  p_zero_base_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_addr_i[31:8] == 24'h0 |-> !claim_o);
endmodule

bind dma_remap_dec dma_remap_dec_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_addr_i (cfg_addr_i),
  .cfg_rdata_o(cfg_rdata_o),
  .io_addr_i  (io_addr_i),
  .io_strobe_i(io_strobe_i),
  .claim_o    (claim_o),
  .chan_o     (chan_o),
  .reg_off_o  (reg_off_o)
);

// File: tb/dma_remap_dec_test.sv
module dma_remap_dec_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [7:0]  cfg_rdata_o;
  logic [31:0] io_addr_i = '0;
  logic        io_strobe_i = 1'b0;
  logic        claim_o;
  logic [2:0]  chan_o;
  logic [3:0]  reg_off_o;

  int total = 0;
  int bad = 0;

  always #4 clk_i = ~clk_i;

  dma_remap_dec uut (.*);

  // {addr, strobe, expected claim}; base 0x123456xx, mask A5h
  localparam int NV = 13;
  localparam logic [33:0] VEC [NV] = '{
    {32'h1234_5600, 1'b1, 1'b1},
    {32'h1234_561F, 1'b1, 1'b0},
    {32'h1234_5625, 1'b1, 1'b1},
    {32'h1234_5630, 1'b1, 1'b0},
    {32'h1234_5640, 1'b1, 1'b0},
    {32'h1234_565A, 1'b1, 1'b1},
    {32'h1234_5660, 1'b1, 1'b0},
    {32'h1234_567F, 1'b1, 1'b1},
    {32'h1234_5680, 1'b1, 1'b0},
    {32'h1234_55FF, 1'b1, 1'b0},
    {32'h1234_5700, 1'b1, 1'b0},
    {32'h1234_5600, 1'b0, 1'b0},
    {32'h9234_5600, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic cfg_rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    cfg_addr_i = a;
    #1;
    chk(req, 32'(cfg_rdata_o), 32'(exp));
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic s, input logic exp);
    io_addr_i = a; io_strobe_i = s;
    #1;
    chk(req, 32'(claim_o), 32'(exp));
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 R3 reset values
    cfg_rd("R1 reset 59", 8'h59, 8'h00);
    cfg_rd("R1 reset 5B", 8'h5B, 8'h00);
    cfg_rd("R3 reset mask", 8'h5C, 8'h00);
    // R9: base zero, all channels enabled
    cfg_wr(8'h5C, 8'hFF);
    probe("R9 zero base", 32'h0000_0010, 1'b1, 1'b0);
    probe("R9 zero base ch7", 32'h0000_0070, 1'b1, 1'b0);
    // R4
    cfg_rd("R4 role bit", 8'h5C, 8'hEF);
    // program base
    cfg_wr(8'h59, 8'h56);
    cfg_wr(8'h5A, 8'h34);
    cfg_wr(8'h5B, 8'h12);
    cfg_wr(8'h58, 8'hFF);
    cfg_rd("R1 byte 59", 8'h59, 8'h56);
    cfg_rd("R1 byte 5A", 8'h5A, 8'h34);
    cfg_rd("R1 byte 5B", 8'h5B, 8'h12);
    cfg_rd("R2 byte 58", 8'h58, 8'h00);
    // R8: all enabled still excludes cascade
    probe("R8 cascade", 32'h1234_5643, 1'b1, 1'b0);
    // R2: window not shifted by 58h write
    probe("R2 base low", 32'h1234_5610, 1'b1, 1'b1);
    cfg_wr(8'h5C, 8'hA5);
    cfg_rd("R3 mask A5", 8'h5C, 8'hA5);
    // vector walk: R5 R6 R7 R8 R10 R11
    for (int i = 0; i < NV; i++) begin
      probe("R5 R6 R7 R11 vec claim", VEC[i][33:2], VEC[i][1], VEC[i][0]);
      chk("R10 chan", 32'(chan_o), 32'(VEC[i][8:6]));
      chk("R10 off", 32'(reg_off_o), 32'(VEC[i][5:2]));
    end
    // R12 other offsets
    cfg_wr(8'h60, 8'hFF);
    cfg_wr(8'h57, 8'hFF);
    cfg_rd("R12 read 60", 8'h60, 8'h00);
    cfg_rd("R12 read 57", 8'h57, 8'h00);
    cfg_rd("R12 mask kept", 8'h5C, 8'hA5);
    probe("R12 claim kept", 32'h1234_5610, 1'b1, 1'b0);
    probe("R12 claim kept ch0", 32'h1234_5608, 1'b1, 1'b1);
    // R7: clear one channel
    cfg_wr(8'h5C, 8'h85);
    probe("R7 ch5 off", 32'h1234_5650, 1'b1, 1'b0);
    probe("R5 ch7 on", 32'h1234_5770 - 32'h100, 1'b1, 1'b1);
    // async reset clears config
    io_strobe_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    cfg_rd("R1 async reset", 8'h5A, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule